// File: doc/BRIEF.md
# Configuration Status LED Driver

This block turns the state of a configuration engine into two indicator outputs: a status lamp and an error lamp. Each lamp is in one of three modes: steady on, blinking, or off. The status lamp follows configuration progress. It is off while the engine is idle, blinks while a configuration is running, and stays on once configuration has completed. The error lamp stays on while an error is flagged. It blinks when the memory card is selected as the configuration source and no card is detected. Otherwise it is off.

Both lamps blink from one free-running prescaler. The prescaler produces a square wave with a 50% duty cycle, and each half-period lasts a set number of clock cycles. Because the two lamps share this wave, they blink in phase. The lamp outputs are registered. Reset turns both lamps off and clears the prescaler. Driving the lamps electrically is outside this block, and so is deriving the configuration state.

Top module: `cfg_led_driver`

## Requirements
- R1: When `cfg_state` is 2'b10 (done), `status_led` is 1 on every cycle.
- R2: When `cfg_state` is 2'b01 (in progress), `status_led` follows the shared blink wave. The wave stays low for `HALF_PERIOD_CYCLES` cycles, then high for the same number of cycles, and repeats.
- R3: When `cfg_state` is 2'b00 (idle), `status_led` is 0. The unused code 2'b11 is treated the same as idle.
- R4: When `cfg_error` is 1, `error_led` is 1.
- R5: When `cfg_error` is 0, `card_src_en` is 1 and `card_present` is 0, `error_led` follows the shared blink wave.
- R6: When `cfg_error` is 0 and the missing-card condition is absent (the card is present, or card sourcing is disabled), `error_led` is 0.
- R7: When an error and the missing-card condition occur together, `error_led` stays steadily on instead of blinking.
- R8: When both lamps are blinking, they show the same value on every cycle.
- R9: While `rst` is 1, both lamps are 0 and the prescaler is cleared. After `rst` is released, the blink wave starts from the start of its low half.
- R10: A change on any input appears on the lamps after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_state | input | 2 | Configuration progress: 00 idle, 01 in progress, 10 done, 11 treated as idle |
| cfg_error | input | 1 | Configuration error present |
| card_present | input | 1 | A memory card is detected |
| card_src_en | input | 1 | The memory card is selected as the configuration source |
| status_led | output | 1 | Status lamp drive, 1 = lit |
| error_led | output | 1 | Error lamp drive, 1 = lit |

## Verification
Two pairs of conditions can arise in the same cycle. The first pair is an error flag and a missing card. The bench drives them together both while the status lamp is blinking and while it is not, and expects the error lamp to be steadily lit. The second pair is an in-progress configuration and a missing card. The bench holds them together across several blink half-periods, and the cycle-by-cycle model expects both lamps to match the same wave. A reset issued in the middle of a blink shows that the wave restarts from its low half.

// File: rtl/cfg_led_pkg.sv
package cfg_led_pkg;

    typedef enum logic [1:0] {
        CFG_IDLE = 2'b00,
        CFG_BUSY = 2'b01,
        CFG_DONE = 2'b10,
        CFG_RSVD = 2'b11
    } cfg_state_t;

    typedef enum logic [1:0] {
        LAMP_OFF   = 2'b00,
        LAMP_BLINK = 2'b01,
        LAMP_ON    = 2'b10
    } lamp_mode_t;

endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
    parameter int HALF_PERIOD_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    localparam int CNT_W = (HALF_PERIOD_CYCLES > 1) ? $clog2(HALF_PERIOD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } presc_t;

    presc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;

    // R2: the counter never runs past the half-period limit.
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);

    // R9: the prescaler comes out of reset cleared.
    assert_presc_clear_R9: assert property (@(posedge clk)
        rst |=> (st_q.cnt == '0 && st_q.phase == 1'b0));

endmodule

// File: rtl/lamp_mode_decoder.sv
module lamp_mode_decoder
    import cfg_led_pkg::*;
(
    input  logic [1:0]  cfg_state,
    input  logic        cfg_error,
    input  logic        card_present,
    input  logic        card_src_en,
    output lamp_mode_t  status_mode,
    output lamp_mode_t  error_mode
);
    logic card_missing;

    always_comb begin
        card_missing = card_src_en & ~card_present;

        unique case (cfg_state)
            CFG_DONE: status_mode = LAMP_ON;
            CFG_BUSY: status_mode = LAMP_BLINK;
            default:  status_mode = LAMP_OFF;
        endcase

        // The error flag takes priority over the missing-card blink.
        if (cfg_error) begin
            error_mode = LAMP_ON;
        end else if (card_missing) begin
            error_mode = LAMP_BLINK;
        end else begin
            error_mode = LAMP_OFF;
        end
    end

endmodule

// File: rtl/lamp_output_stage.sv
module lamp_output_stage
    import cfg_led_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       phase,
    input  lamp_mode_t status_mode,
    input  lamp_mode_t error_mode,
    output logic       status_led,
    output logic       error_led
);
    typedef struct packed {
        logic status;
        logic error;
    } lamps_t;

    lamps_t lamp_d, lamp_q;

    function automatic logic render(input lamp_mode_t m, input logic ph);
        case (m)
            LAMP_ON:    return 1'b1;
            LAMP_BLINK: return ph;
            default:    return 1'b0;
        endcase
    endfunction

    always_comb begin
        lamp_d.status = render(status_mode, phase);
        lamp_d.error  = render(error_mode, phase);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lamp_q <= '0;
        end else begin
            lamp_q <= lamp_d;
        end
    end

    assign status_led = lamp_q.status;
    assign error_led  = lamp_q.error;

    // R8: two blinking lamps take the same value, one edge later.
    assert_blink_in_phase_R8: assert property (@(posedge clk) disable iff (rst)
        (status_mode == LAMP_BLINK && error_mode == LAMP_BLINK) |=> (status_led == error_led));

    // R10: a blink mode copies the prescaler phase across one edge.
    assert_blink_tracks_phase_R10: assert property (@(posedge clk) disable iff (rst)
        (status_mode == LAMP_BLINK) |=> (status_led == $past(phase)));

endmodule

// File: rtl/cfg_led_driver.sv
module cfg_led_driver
    import cfg_led_pkg::*;
#(
    parameter int HALF_PERIOD_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_state,
    input  logic       cfg_error,
    input  logic       card_present,
    input  logic       card_src_en,
    output logic       status_led,
    output logic       error_led
);
    logic       phase;
    lamp_mode_t status_mode;
    lamp_mode_t error_mode;

    blink_prescaler #(
        .HALF_PERIOD_CYCLES(HALF_PERIOD_CYCLES)
    ) u_presc (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    lamp_mode_decoder u_dec (
        .cfg_state    (cfg_state),
        .cfg_error    (cfg_error),
        .card_present (card_present),
        .card_src_en  (card_src_en),
        .status_mode  (status_mode),
        .error_mode   (error_mode)
    );

    lamp_output_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .status_mode (status_mode),
        .error_mode  (error_mode),
        .status_led  (status_led),
        .error_led   (error_led)
    );

    assert_done_on_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_state == CFG_DONE) |=> status_led);

    assert_idle_off_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_state == CFG_IDLE || cfg_state == CFG_RSVD) |=> !status_led);

    assert_error_on_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_error |=> error_led);

    assert_error_off_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_error && !(card_src_en && !card_present)) |=> !error_led);

    assert_error_priority_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_error && card_src_en && !card_present) |=> error_led);

    assert_reset_dark_R9: assert property (@(posedge clk)
        rst |=> (!status_led && !error_led));

endmodule

// File: tb/tb_cfg_led_driver.sv
module tb_cfg_led_driver;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_state = 2'b00;
    logic       cfg_error = 1'b0;
    logic       card_present = 1'b1;
    logic       card_src_en = 1'b0;
    logic       status_led;
    logic       error_led;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  exp_s;
        logic  exp_e;
        string tag_s;
        string tag_e;
    } exp_t;

    exp_t sb[$];

    cfg_led_driver #(.HALF_PERIOD_CYCLES(HALF)) dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_state    (cfg_state),
        .cfg_error    (cfg_error),
        .card_present (card_present),
        .card_src_en  (card_src_en),
        .status_led   (status_led),
        .error_led    (error_led)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expectation side: at every edge compute what the lamps must show
    // after that edge (R10: the inputs seen at the edge take effect there).
    int k = 0;
    always @(posedge clk) begin
        exp_t e;
        logic ph;
        if (rst) begin
            k = 0;
            e.exp_s = 1'b0; e.exp_e = 1'b0;
            e.tag_s = "R9"; e.tag_e = "R9";
        end else begin
            k = k + 1;
            ph = (((k - 1) / HALF) % 2) == 1;
            case (cfg_state)
                2'b10:   begin e.exp_s = 1'b1; e.tag_s = "R1"; end
                2'b01:   begin e.exp_s = ph;   e.tag_s = (k <= HALF) ? "R9" : "R2"; end
                default: begin e.exp_s = 1'b0; e.tag_s = "R3"; end
            endcase
            if (cfg_error) begin
                e.exp_e = 1'b1;
                e.tag_e = (card_src_en && !card_present) ? "R7" : "R4";
            end else if (card_src_en && !card_present) begin
                e.exp_e = ph;
                e.tag_e = (cfg_state == 2'b01) ? "R8" : "R5";
            end else begin
                e.exp_e = 1'b0;
                e.tag_e = "R6";
            end
        end
        sb.push_back(e);
    end

    // Monitor: compare a quarter period after each edge.
    always @(posedge clk) begin
        exp_t e;
        #(CLK_PERIOD/4);
        if (sb.size() > 0) begin
            e = sb.pop_front();
            total++;
            if (status_led !== e.exp_s) begin
                bad++;
                $display("FAIL %s status_led actual=%b expected=%b", e.tag_s, status_led, e.exp_s);
            end
            total++;
            if (error_led !== e.exp_e) begin
                bad++;
                $display("FAIL %s error_led actual=%b expected=%b", e.tag_e, error_led, e.exp_e);
            end
        end
    end

    task automatic drive(input logic [1:0] st, input logic er, input logic pres,
                         input logic en, input int cycles);
        @(negedge clk);
        cfg_state    = st;
        cfg_error    = er;
        card_present = pres;
        card_src_en  = en;
        repeat (cycles - 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(2'b00, 0, 1, 0, 4);                 // R3 idle, R6 no error
        drive(2'b10, 0, 1, 0, 4);                 // R1 done
        drive(2'b01, 0, 1, 0, 4 * HALF + 1);      // R2 blink, R9 low half first
        drive(2'b11, 0, 1, 0, 3);                 // R3 unused code
        drive(2'b00, 1, 1, 0, 3);                 // R4 error on
        drive(2'b00, 0, 0, 1, 3 * HALF);          // R5 missing-card blink
        drive(2'b00, 0, 0, 0, 3);                 // R6 card sourcing disabled
        drive(2'b01, 0, 0, 1, 4 * HALF);          // R8 both blink together
        drive(2'b01, 1, 0, 1, 2 * HALF);          // R7 error beats missing card
        drive(2'b10, 1, 0, 1, 2);                 // R7 with status steady
        // R10: single-cycle changes each show after one edge
        drive(2'b10, 0, 1, 0, 1);
        drive(2'b00, 1, 1, 0, 1);
        drive(2'b10, 0, 1, 1, 1);
        drive(2'b00, 0, 1, 1, 1);
        // R9: reset in mid-blink restarts the wave in its low half
        drive(2'b01, 0, 0, 1, HALF + 1);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        drive(2'b01, 0, 0, 1, 3 * HALF);
        drive(2'b00, 0, 1, 0, 2);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule